// File: doc/BRIEF.md
# I/O Port Permission Bitmap Checker

This block decides whether a port I/O access of one, two or four bytes may go ahead. It first checks the cached task-segment descriptor: it must be present, of the available 32-bit task type, and large enough to hold the fixed header. It then fetches a 16-bit pointer to the permission bitmap from inside the segment, and finally reads the two bitmap bytes that cover the addressed port.

The result is either "allow" or a general-protection fault with a zero error code. A check starts with a one-cycle `start` pulse carrying the port and the size. The block then issues zero, one or two 16-bit reads over a request/response memory port. It ends with a one-cycle `done` pulse, with `fault` valid in that cycle. Performing the I/O and delivering the exception are left to the surrounding logic.

Top module: `io_perm_checker`

## Requirements
- R1: After reset the block is idle: `done`, `fault` and `mem_req` are low.
- R2: If the descriptor is not present, its 4-bit type is not 9, or its limit is below 103, the check ends with `fault` high and no memory read. `done` rises in the cycle after `start` is accepted.
- R3: The first read is at segment base + 0x66. The 16-bit `mem_rdata` word, low byte at the lower address, is taken as the bitmap offset.
- R4: The byte offset is the bitmap offset plus (port >> 3), computed without wrap-around. The second read is at segment base + byte offset.
- R5: If byte offset + 1 is greater than the segment limit, the check ends with `fault` high after only the first read.
- R6: The second word is shifted right by (port & 7) and masked by the size code: 0 keeps 1 bit, 1 keeps 2 bits, 2 or 3 keeps 4 bits. Any set bit that is kept gives `fault` high.
- R7: When all kept bits are zero, the check ends with `done` high for exactly one cycle and `fault` low. `fault` is never high without `done`.
- R8: A `start` that arrives while a check is in progress is ignored. The running check completes with its own result, and exactly one `done` is produced.
- R9: `mem_req` stays high with a stable `mem_addr` until `mem_valid` is seen. The read latency may be any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a check (accepted only when idle) |
| port | input | 16 | I/O port number |
| size_code | input | 2 | Access size: 0 byte, 1 word, 2 or 3 double word |
| desc_present | input | 1 | Task-segment descriptor present bit |
| desc_type | input | 4 | Task-segment descriptor type field |
| desc_base | input | 32 | Task-segment base address |
| desc_limit | input | 32 | Task-segment limit (last valid byte offset) |
| mem_req | output | 1 | Read request, held until `mem_valid` |
| mem_addr | output | 32 | Byte address of the 16-bit read |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data, low byte at the lower address |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Access denied (general-protection fault, error code 0), valid with `done` |

## Verification
Descriptors are varied one field at a time: not present, wrong type, limit 102 and limit 103. This shows that each validity term alone blocks the access without any bus traffic. Ports and sizes are chosen so that the kept bits fall on a set bit, on clear bits, and across a byte boundary. This separates a correct shift and mask from an off-by-one or a single-byte fetch. Offsets placed so that byte offset + 1 equals the limit, or exceeds it by one, pin down the bounds comparison. An offset of 0xFFFF shows whether the sum wraps. Varied read latency and a second `start` sent mid-check cover the handshake.

// File: rtl/iopb_pkg.sv
package iopb_pkg;
    localparam int PORT_W     = 16;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 16;
    localparam int BIT_SEL_W  = 3;
    localparam int MASK_W     = 4;
    localparam int OFS_W      = ((PORT_W - BIT_SEL_W) > WORD_W ? (PORT_W - BIT_SEL_W) : WORD_W) + 1;
    localparam logic [3:0] TASK_TYPE_AVAIL32 = 4'h9;
    localparam logic [ADDR_W-1:0] MIN_TASK_LIMIT = ADDR_W'(103);
    localparam logic [ADDR_W-1:0] MAP_PTR_OFS    = ADDR_W'(16'h0066);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_PTR = 2'd1,
        ST_RD_MAP = 2'd2,
        ST_FIN    = 2'd3
    } chk_state_t;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_DWALT = 2'd3
    } acc_size_t;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        acc_size_t         size;
    } chk_req_t;

    function automatic logic [MASK_W-1:0] size_mask(acc_size_t sz);
        case (sz)
            SZ_BYTE: size_mask = 4'b0001;
            SZ_WORD: size_mask = 4'b0011;
            default: size_mask = 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/iopb_desc_check.sv
module iopb_desc_check
    import iopb_pkg::*;
(
    input  logic              present,
    input  logic [3:0]        seg_type,
    input  logic [ADDR_W-1:0] limit,
    output logic              ok
);
    always_comb begin
        ok = present && (seg_type == TASK_TYPE_AVAIL32) && (limit >= MIN_TASK_LIMIT);
    end
endmodule

// File: rtl/iopb_bit_test.sv
module iopb_bit_test
    import iopb_pkg::*;
(
    input  logic [WORD_W-1:0]    map_word,
    input  logic [BIT_SEL_W-1:0] bit_sel,
    input  acc_size_t            size,
    output logic                 deny
);
    logic [WORD_W-1:0] shifted;
    logic [MASK_W-1:0] kept;

    always_comb begin
        shifted = map_word >> bit_sel;
        kept    = shifted[MASK_W-1:0] & size_mask(size);
        deny    = |kept;
    end
endmodule

// File: rtl/io_perm_checker.sv
module io_perm_checker
    import iopb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [15:0]       port,
    input  logic [1:0]        size_code,
    input  logic              desc_present,
    input  logic [3:0]        desc_type,
    input  logic [31:0]       desc_base,
    input  logic [31:0]       desc_limit,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_valid,
    input  logic [15:0]       mem_rdata,
    output logic              done,
    output logic              fault
);
    chk_state_t        state;
    chk_req_t          req_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] limit_q;
    logic [ADDR_W-1:0] addr_q;
    logic              fault_q;

    logic              desc_ok;
    logic              map_deny;
    logic [OFS_W-1:0]  byte_ofs;
    logic [ADDR_W:0]   last_byte;
    logic              out_of_bounds;

    iopb_desc_check u_desc (
        .present  (desc_present),
        .seg_type (desc_type),
        .limit    (desc_limit),
        .ok       (desc_ok)
    );

    iopb_bit_test u_bits (
        .map_word (mem_rdata),
        .bit_sel  (req_q.port[BIT_SEL_W-1:0]),
        .size     (req_q.size),
        .deny     (map_deny)
    );

    always_comb begin
        byte_ofs      = OFS_W'(mem_rdata) + OFS_W'(req_q.port >> BIT_SEL_W);
        last_byte     = (ADDR_W+1)'(byte_ofs) + (ADDR_W+1)'(1);
        out_of_bounds = last_byte > {1'b0, limit_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            req_q   <= '0;
            base_q  <= '0;
            limit_q <= '0;
            addr_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        req_q   <= '{port: port, size: acc_size_t'(size_code)};
                        base_q  <= desc_base;
                        limit_q <= desc_limit;
                        if (desc_ok) begin
                            fault_q <= 1'b0;
                            addr_q  <= desc_base + MAP_PTR_OFS;
                            state   <= ST_RD_PTR;
                        end else begin
                            fault_q <= 1'b1;
                            state   <= ST_FIN;
                        end
                    end
                end
                ST_RD_PTR: begin
                    if (mem_valid) begin
                        if (out_of_bounds) begin
                            fault_q <= 1'b1;
                            state   <= ST_FIN;
                        end else begin
                            addr_q <= base_q + ADDR_W'(byte_ofs);
                            state  <= ST_RD_MAP;
                        end
                    end
                end
                ST_RD_MAP: begin
                    if (mem_valid) begin
                        fault_q <= map_deny;
                        state   <= ST_FIN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req  = (state == ST_RD_PTR) || (state == ST_RD_MAP);
    assign mem_addr = addr_q;
    assign done     = (state == ST_FIN);
    assign fault    = done & fault_q;

    // R2: a rejected descriptor finishes at once with a fault, no read
    a_r2_bad_desc_no_read: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && !desc_ok) |=> (done && fault && !mem_req));

    // R9: a pending read keeps its request and address
    a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: fault is only reported together with done
    a_r7_fault_with_done: assert property (@(posedge clk) disable iff (rst)
        fault |-> done);

    // R8: a busy block never turns a start into a new first read
    a_r8_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_MAP && !mem_valid && start) |=> (state == ST_RD_MAP));

    // R5: bounds failure ends the check without a second read
    a_r5_bounds_stop: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_PTR && mem_valid && out_of_bounds) |=> (done && fault));
endmodule

// File: tb/io_perm_checker_bench.sv
module io_perm_checker_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] port;
    logic [1:0]  size_code;
    logic        desc_present;
    logic [3:0]  desc_type;
    logic [31:0] desc_base;
    logic [31:0] desc_limit;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid;
    logic [15:0] mem_rdata;
    logic        done;
    logic        fault;

    always #5 clk = ~clk;

    io_perm_checker u_io_perm_checker (
        .clk(clk), .rst(rst), .start(start), .port(port), .size_code(size_code),
        .desc_present(desc_present), .desc_type(desc_type),
        .desc_base(desc_base), .desc_limit(desc_limit),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .done(done), .fault(fault)
    );

    localparam logic [31:0] BASE = 32'h0000_0400;

    typedef struct {
        bit          fault;
        int          nreads;
        logic [31:0] a0;
        logic [31:0] a1;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [7:0]  ram [0:4095];
    int          lat = 0;
    int          cnt = 0;
    int          seen_n = 0;
    logic [31:0] seen_a [0:3];
    int          dones = 0;
    int          errors = 0;
    int          checks = 0;
    bit          finished = 0;

    function automatic logic [15:0] rd16(logic [31:0] a);
        return {ram[(a + 1) & 32'hFFF], ram[a & 32'hFFF]};
    endfunction

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // memory model: answers a held request after lat cycles
    always @(negedge clk) begin
        if (rst) begin
            mem_valid = 1'b0;
            cnt = 0;
        end else if (mem_valid) begin
            mem_valid = 1'b0;
            cnt = 0;
        end else if (mem_req) begin
            if (cnt >= lat) begin
                mem_valid = 1'b1;
                mem_rdata = rd16(mem_addr);
                if (seen_n < 4) seen_a[seen_n] = mem_addr;
                seen_n++;
            end else begin
                cnt++;
            end
        end
    end

    // monitor: compares each completion against the scoreboard
    always @(negedge clk) begin
        if (!rst && done) begin
            dones++;
            if (sb.size() == 0) begin
                check(0, "R8 unexpected done", 64'(dones), 64'(dones - 1));
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(fault == e.fault, {e.tag, " fault"}, 64'(fault), 64'(e.fault));
                check(seen_n == e.nreads, {e.tag, " read count"}, 64'(seen_n), 64'(e.nreads));
                if (e.nreads >= 1 && seen_n >= 1)
                    check(seen_a[0] == e.a0, {e.tag, " R3 pointer address"}, 64'(seen_a[0]), 64'(e.a0));
                if (e.nreads >= 2 && seen_n >= 2)
                    check(seen_a[1] == e.a1, {e.tag, " R4 bitmap address"}, 64'(seen_a[1]), 64'(e.a1));
            end
            seen_n = 0;
        end
    end

    // driver: computes the expected outcome and pushes it, then starts
    task automatic run(input string tag, input logic [15:0] p, input logic [1:0] sz,
                       input bit pres, input logic [3:0] ty, input logic [31:0] lim,
                       input logic [15:0] map_ptr, input bit poke);
        exp_t e;
        logic [32:0] bo;
        logic [15:0] w;
        logic [3:0]  m;
        int          target;
        ram[(BASE + 32'h66) & 32'hFFF]     = map_ptr[7:0];
        ram[(BASE + 32'h67) & 32'hFFF]     = map_ptr[15:8];
        e.tag = tag; e.a0 = BASE + 32'h66; e.a1 = 0;
        if (!pres || ty != 4'h9 || lim < 103) begin
            e.fault = 1; e.nreads = 0;
        end else begin
            bo = 33'(map_ptr) + 33'(p >> 3);
            if (bo + 1 > 33'(lim)) begin
                e.fault = 1; e.nreads = 1;
            end else begin
                e.nreads = 2;
                e.a1 = BASE + bo[31:0];
                w = rd16(e.a1) >> p[2:0];
                m = (sz == 2'd0) ? 4'b0001 : (sz == 2'd1) ? 4'b0011 : 4'b1111;
                e.fault = (w[3:0] & m) != 0;
            end
        end
        sb.push_back(e);
        target = dones + 1;
        @(negedge clk);
        start = 1; port = p; size_code = sz;
        desc_present = pres; desc_type = ty; desc_base = BASE; desc_limit = lim;
        @(negedge clk);
        start = 0;
        if (poke) begin
            @(negedge clk);
            // R8: second start while busy, aimed at a denied port
            start = 1; port = 16'd7; size_code = 2'd0;
            @(negedge clk);
            start = 0;
        end
        wait (dones >= target);
        repeat (3) @(negedge clk);
        check(dones == target, {tag, " R8 done count"}, 64'(dones), 64'(target));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) ram[i] = 8'h00;
        ram[(BASE + 32'h68) & 32'hFFF] = 8'h80;
        ram[(BASE + 32'h69) & 32'hFFF] = 8'h01;
        ram[(BASE + 32'h6A) & 32'hFFF] = 8'h00;
        ram[(BASE + 32'h6B) & 32'hFFF] = 8'hF0;
        rst = 1; start = 0; port = 0; size_code = 0;
        desc_present = 0; desc_type = 0; desc_base = 0; desc_limit = 0;
        mem_valid = 0; mem_rdata = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(done == 0 && fault == 0 && mem_req == 0, "R1 reset idle",
              64'({done, fault, mem_req}), 64'(0));

        // R2: each descriptor term alone
        run("R2 not present", 16'd0, 2'd0, 0, 4'h9, 32'h100, 16'h0068, 0);
        run("R2 busy type",   16'd0, 2'd0, 1, 4'hB, 32'h100, 16'h0068, 0);
        run("R2 limit 102",   16'd0, 2'd0, 1, 4'h9, 32'd102, 16'h0068, 0);
        // limit 103 valid; pointer 0x66 makes byte offset+1 equal 103
        run("R5 limit 103 fits", 16'd0, 2'd0, 1, 4'h9, 32'd103, 16'h0066, 0);
        run("R5 limit 103 over", 16'd8, 2'd0, 1, 4'h9, 32'd103, 16'h0066, 0);
        // R6/R7: bit patterns
        run("R7 port0 byte allow",   16'd0,  2'd0, 1, 4'h9, 32'h100, 16'h0068, 0);
        run("R6 port7 byte deny",    16'd7,  2'd0, 1, 4'h9, 32'h100, 16'h0068, 0);
        run("R7 port5 word allow",   16'd5,  2'd1, 1, 4'h9, 32'h100, 16'h0068, 0);
        run("R6 port6 dword cross",  16'd6,  2'd2, 1, 4'h9, 32'h100, 16'h0068, 0);
        run("R6 port7 word cross",   16'd7,  2'd1, 1, 4'h9, 32'h100, 16'h0068, 0);
        run("R7 port9 dword allow",  16'd9,  2'd2, 1, 4'h9, 32'h100, 16'h0068, 0);
        run("R7 port20 dword allow", 16'd20, 2'd3, 1, 4'h9, 32'h100, 16'h0068, 0);
        run("R6 port28 code3 deny",  16'd28, 2'd3, 1, 4'h9, 32'h100, 16'h0068, 0);
        // R4/R5: bounds around the limit
        run("R4 last byte fits", 16'h04B8, 2'd0, 1, 4'h9, 32'h100, 16'h0068, 0);
        run("R5 one past limit", 16'h04C0, 2'd0, 1, 4'h9, 32'h100, 16'h0068, 0);
        run("R4 no wrap ptr FFFF", 16'hFFF8, 2'd0, 1, 4'h9, 32'h100, 16'hFFFF, 0);
        // R9: slower memory
        lat = 3;
        run("R9 slow allow", 16'd0, 2'd0, 1, 4'h9, 32'h100, 16'h0068, 0);
        run("R9 slow deny",  16'd8, 2'd0, 1, 4'h9, 32'h100, 16'h0068, 0);
        // R8: start while busy is ignored
        run("R8 poke mid check", 16'd16, 2'd2, 1, 4'h9, 32'h100, 16'h0068, 1);
        lat = 0;
        run("R8 after poke", 16'd3, 2'd0, 1, 4'h9, 32'h100, 16'h0068, 0);
        check(sb.size() == 0, "R8 scoreboard drained", 64'(sb.size()), 64'(0));

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule